// File: doc/BRIEF.md
# Serial controller interrupt status logic

This block keeps the interrupt state of a serial controller. Three raw event pulses come from the transfer engine: transmit done, receive ready and receive overflow. Each pulse sets a sticky raw bit. That bit stays set until software clears it by writing a one to the matching position of a clear register.

The control word carries one enable per source. These enables sit at different bit positions from the status layout. The block moves each enable onto its status position and ANDs the result with the raw state to form the masked state. The single interrupt line is high while any masked bit is set.

The masked state is formed again from raw state and enables in every cycle. So a clear, or a dropped enable, removes the masked bit straight away. Register decode and the sources of the events belong to other blocks.

Top module: `serial_irq_status`

## Requirements
- R1: After a synchronous active-low reset, raw_status and masked_status are 3'b000 and irq is low.
- R2: Each source has a raw bit at a fixed position: bit 0 is transmit done, bit 1 is receive ready and bit 2 is receive overflow. An event pulse sets its raw bit on the next clock edge, and the bit stays set until it is cleared.
- R3: ctrl_word bit 5 enables raw bit 0, bit 4 enables raw bit 1 and bit 6 enables raw bit 2. All other ctrl_word bits have no effect.
- R4: masked_status equals raw_status ANDed with the remapped enables. It follows an enable change in the same cycle.
- R5: irq is high exactly when masked_status is nonzero.
- R6: In a cycle with clr_wr high, a one in clr_data bit 0, 1 or 2 clears the matching raw bit on the next edge. Zeros in bits 0 to 2 and any value in clr_data bits 31 to 3 have no effect. clr_data is ignored while clr_wr is low.
- R7: Clearing a raw bit also clears its masked bit and removes its contribution to irq.
- R8: When an event and a clear for the same bit arrive in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 32 | Control word that carries the per-source enables |
| evt_tx_done | input | 1 | Transmit-done event pulse |
| evt_rx_ready | input | 1 | Receive-ready event pulse |
| evt_rx_ovf | input | 1 | Receive-overflow event pulse |
| clr_wr | input | 1 | Write strobe for the clear register |
| clr_data | input | 32 | Write-one-to-clear data |
| raw_status | output | 3 | Sticky raw event state |
| masked_status | output | 3 | Raw state ANDed with the remapped enables |
| irq | output | 1 | Interrupt line, high while any masked bit is set |

## Verification
Two functions of this block can fall in the same cycle: a raw event setting a bit, and a software clear of that bit. The bench provokes this in two ways. It pulses one source while the clear names that source and a second bit. It also pulses all three sources together with a full clear. It then judges the result on the raw, masked and interrupt outputs after the edge: the pulsed bits must be set and only the other cleared bit may be dropped.

// File: rtl/serial_irq_pkg.sv
// Package: shared sizes and bit positions for the interrupt status logic.
// Assumes three sources laid out in the order: transmit done, receive
// ready, receive overflow.
package serial_irq_pkg;
    localparam int NUM_SRC = 3;
    localparam int CTRL_W  = 32;
    localparam int CLR_W   = 32;

    // Status positions
    localparam int ST_TX_DONE  = 0;
    localparam int ST_RX_READY = 1;
    localparam int ST_RX_OVF   = 2;

    // Enable positions in the control word
    localparam int EN_RX_READY = 4;
    localparam int EN_TX_DONE  = 5;
    localparam int EN_RX_OVF   = 6;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Control-word bit that enables a given status position
    function automatic int enable_pos(input int status_idx);
        case (status_idx)
            ST_TX_DONE:  return EN_TX_DONE;
            ST_RX_READY: return EN_RX_READY;
            default:     return EN_RX_OVF;
        endcase
    endfunction
endpackage

// File: rtl/irq_enable_remap.sv
// Module: irq_enable_remap
// Moves the per-source enables out of the control word onto the status bit
// layout. Purely combinational. Assumes every enable position lies inside
// the control word.
module irq_enable_remap
    import serial_irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int CW    = CTRL_W
) (
    input  logic [CW-1:0]    ctrl_word,
    output logic [N_SRC-1:0] enables
);
    // One wire per status position, picked from its control-word position
    for (genvar g = 0; g < N_SRC; g++) begin : g_map
        localparam int POS = enable_pos(g);
        assign enables[g] = ctrl_word[POS];
    end
endmodule

// File: rtl/irq_raw_latch.sv
// Module: irq_raw_latch
// Sticky raw event bits with write-one-to-clear. An event beats a clear of
// the same bit in the same cycle. Assumes event pulses are synchronous to clk.
module irq_raw_latch #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] events,
    input  logic [N_SRC-1:0] clears,
    output logic [N_SRC-1:0] raw_q
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_bit
        // Set on event, else clear on request, else hold
        always_ff @(posedge clk) begin
            if (!rst_n)         raw_q[g] <= 1'b0;
            else if (events[g]) raw_q[g] <= 1'b1;
            else if (clears[g]) raw_q[g] <= 1'b0;
        end

        p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_q[g] && !clears[g]) |=> raw_q[g]);
        p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            events[g] |=> raw_q[g]);
        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clears[g] && !events[g]) |=> !raw_q[g]);
    end
endmodule

// File: rtl/irq_mask_reduce.sv
// Module: irq_mask_reduce
// Combines raw state with the enables to form the masked state, and reduces
// it to the interrupt line. Combinational. Masked state is formed again
// every cycle, so there is no stale masked bit.
module irq_mask_reduce #(
    parameter int N_SRC = 3
) (
    input  logic [N_SRC-1:0] raw,
    input  logic [N_SRC-1:0] enables,
    output logic [N_SRC-1:0] masked,
    output logic             irq
);
    // Gate raw bits and OR them down to one line
    always_comb begin
        masked = raw & enables;
        irq    = |masked;
    end
endmodule

// File: rtl/serial_irq_status.sv
// Module: serial_irq_status
// Top of the interrupt status logic: raw latch, enable remap and mask
// reduction. Assumes clr_wr is a one-cycle strobe from register decode.
module serial_irq_status
    import serial_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              evt_tx_done,
    input  logic              evt_rx_ready,
    input  logic              evt_rx_ovf,
    input  logic              clr_wr,
    input  logic [CLR_W-1:0]  clr_data,
    output logic [NUM_SRC-1:0] raw_status,
    output logic [NUM_SRC-1:0] masked_status,
    output logic              irq
);
    src_vec_t events;
    src_vec_t clears;
    src_vec_t enables;

    // Gather event pulses into the status layout, and qualify clears by the strobe
    always_comb begin
        events              = '0;
        events[ST_TX_DONE]  = evt_tx_done;
        events[ST_RX_READY] = evt_rx_ready;
        events[ST_RX_OVF]   = evt_rx_ovf;
        clears              = clr_wr ? clr_data[NUM_SRC-1:0] : '0;
    end

    irq_enable_remap #(.N_SRC(NUM_SRC), .CW(CTRL_W)) u_remap (
        .ctrl_word (ctrl_word),
        .enables   (enables)
    );

    irq_raw_latch #(.N_SRC(NUM_SRC)) u_raw (
        .clk    (clk),
        .rst_n  (rst_n),
        .events (events),
        .clears (clears),
        .raw_q  (raw_status)
    );

    irq_mask_reduce #(.N_SRC(NUM_SRC)) u_mask (
        .raw     (raw_status),
        .enables (enables),
        .masked  (masked_status),
        .irq     (irq)
    );

    p_masked_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_status & ~raw_status) == '0);
    p_irq_needs_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_status != '0));
    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (raw_status == '0));
    p_cleared_drops_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clears[ST_RX_READY] && !events[ST_RX_READY]) |=> !masked_status[ST_RX_READY]);
endmodule

// File: tb/tb_serial_irq_status.sv
module tb_serial_irq_status;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ctrl_word;
    logic        evt_tx_done, evt_rx_ready, evt_rx_ovf;
    logic        clr_wr;
    logic [31:0] clr_data;
    logic [2:0]  raw_status, masked_status;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    serial_irq_status dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .evt_tx_done(evt_tx_done), .evt_rx_ready(evt_rx_ready), .evt_rx_ovf(evt_rx_ovf),
        .clr_wr(clr_wr), .clr_data(clr_data),
        .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
    );

    // Vector: ctrl[7:0], events{ovf,rx,tx}, clr_wr, clr[7:0], raw, masked, irq
    localparam int NV = 12;
    localparam logic [26:0] VECS [0:NV-1] = '{
        {8'h00, 3'b001, 1'b0, 8'h00, 3'b001, 3'b000, 1'b0}, // R2 set, not enabled
        {8'h20, 3'b000, 1'b0, 8'h00, 3'b001, 3'b001, 1'b1}, // R3 bit5 -> bit0
        {8'h10, 3'b000, 1'b0, 8'h00, 3'b001, 3'b000, 1'b0}, // R4 enable drop
        {8'h10, 3'b010, 1'b0, 8'h00, 3'b011, 3'b010, 1'b1}, // R3 bit4 -> bit1
        {8'h8F, 3'b000, 1'b0, 8'h00, 3'b011, 3'b000, 1'b0}, // R3 other bits
        {8'h40, 3'b100, 1'b0, 8'h00, 3'b111, 3'b100, 1'b1}, // R3 bit6 -> bit2
        {8'h70, 3'b000, 1'b1, 8'hF8, 3'b111, 3'b111, 1'b1}, // R6 zeros / high bits
        {8'h70, 3'b000, 1'b0, 8'h07, 3'b111, 3'b111, 1'b1}, // R6 no strobe
        {8'h70, 3'b000, 1'b1, 8'h02, 3'b101, 3'b101, 1'b1}, // R6 R7 clear bit1
        {8'h70, 3'b001, 1'b1, 8'h05, 3'b001, 3'b001, 1'b1}, // R8 event wins bit0
        {8'h70, 3'b000, 1'b1, 8'h01, 3'b000, 3'b000, 1'b0}, // R7 R5 last clear
        {8'h70, 3'b111, 1'b1, 8'h07, 3'b111, 3'b111, 1'b1}  // R8 all together
    };

    task automatic check(input string req, input logic [2:0] er, input logic [2:0] em, input logic ei);
        n_checks++;
        if (raw_status !== er || masked_status !== em || irq !== ei) begin
            n_fail++;
            $display("FAIL %s: raw=%b masked=%b irq=%b expected raw=%b masked=%b irq=%b",
                     req, raw_status, masked_status, irq, er, em, ei);
        end
    endtask

    task automatic idle();
        evt_tx_done = 0; evt_rx_ready = 0; evt_rx_ovf = 0;
        clr_wr = 0; clr_data = '0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: timeout actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; ctrl_word = 32'h70; idle();
        repeat (3) @(posedge clk);
        #5 check("R1 reset", 3'b000, 3'b000, 1'b0);
        @(negedge clk) rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ctrl_word    = {24'h0, VECS[i][26:19]};
            evt_rx_ovf   = VECS[i][18];
            evt_rx_ready = VECS[i][17];
            evt_tx_done  = VECS[i][16];
            clr_wr       = VECS[i][15];
            clr_data     = {24'h0, VECS[i][14:7]};
            @(posedge clk);
            #5 check($sformatf("vector %0d", i), VECS[i][6:4], VECS[i][3:1], VECS[i][0]);
        end

        // R3: wide control word with every non-enable bit set
        @(negedge clk); idle(); ctrl_word = 32'hFFFF_FF8F;
        #1 check("R3 upper ctrl bits", 3'b111, 3'b000, 1'b0);
        // R4: enabling follows in the same cycle
        ctrl_word = 32'h0000_0040;
        #1 check("R4 same-cycle enable", 3'b111, 3'b100, 1'b1);
        // R6: clear with only upper bits set keeps state
        clr_wr = 1; clr_data = 32'hFFFF_FFF8;
        @(posedge clk);
        #5 check("R6 upper clear bits", 3'b111, 3'b100, 1'b1);
        // R7: clearing the enabled bit drops irq
        @(negedge clk); clr_data = 32'h4;
        @(posedge clk);
        #5 check("R7 clear drops irq", 3'b011, 3'b000, 1'b0);
        // R2: sticky across idle cycles
        @(negedge clk); idle();
        repeat (3) @(posedge clk);
        #5 check("R2 sticky", 3'b011, 3'b000, 1'b0);
        // R1: reset mid-run clears state
        @(negedge clk); rst_n = 0; ctrl_word = 32'h70;
        @(posedge clk);
        #5 check("R1 reset mid-run", 3'b000, 3'b000, 1'b0);
        @(negedge clk); rst_n = 1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule